// File: doc/BRIEF.md
# Streaming Window-Reuse FIR Engine

This block evaluates a fixed five-tap FIR filter over a block of signed samples arriving on a valid/ready stream. Results leave on a second valid/ready stream. A `start` pulse opens a block of `BLOCK_LEN` samples. For every output position k in the range 0 to `BLOCK_LEN`-5, the engine produces the weighted sum of the five samples that begin at k. The tap weights rise in odd steps from 3 to 11.

Sample intake and result delivery are decoupled from the arithmetic. A six-entry window holds the overlapping samples, so each input word is taken from the stream exactly once. Each time the window fills, it fires a two-lane datapath. That datapath computes two neighbouring output positions from the same window in a two-stage multiply and add pipeline. Both results go into an output FIFO that drains one word per cycle. When the output side stalls, the stall reaches back through the pipeline to the intake, and no result is lost. A one-cycle `done` pulse marks the end of the block.

Top module: `fir_win_stream`

## Requirements
- R1: After reset, and at any time no block is running, `in_ready_o`, `out_valid_o` and `done_o` are low. `in_ready_o` stays low until `start_i` is seen while idle.
- R2: Output number k equals 3*x[k] + 5*x[k+1] + 7*x[k+2] + 9*x[k+3] + 11*x[k+4]. The inputs are 16-bit two's complement. The result is an exact 22-bit two's complement value with no saturation.
- R3: A block delivers exactly `BLOCK_LEN`-4 results in ascending k, with none lost or repeated.
- R4: A block accepts exactly `BLOCK_LEN` samples. `in_ready_o` is low from the acceptance of the last sample until the next block starts.
- R5: When the result count is odd, the final window fires with only its lower position valid, and that value is still correct by R2.
- R6: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` keeps its value on the next cycle.
- R7: `done_o` is high for exactly one cycle: the cycle after the last result of a block is accepted. It is low at every other time.
- R8: A `start_i` pulse during a running block is ignored. The block completes with the same samples and results.
- R9: No result appears before six samples of the block have been accepted, or all of them if the block is shorter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a block when the engine is idle |
| done_o | output | 1 | One-cycle pulse after the last result is taken |
| in_valid_i | input | 1 | Sample word valid |
| in_data_i | input | DATA_W (16) | Signed sample |
| in_ready_o | output | 1 | Engine takes the sample this cycle |
| out_valid_o | output | 1 | Result word valid |
| out_data_o | output | ACC_W (22) | Signed filter result |
| out_ready_i | input | 1 | Consumer takes the result this cycle |

## Verification
The bench builds two copies of the engine. The first uses the default 516-sample block with a four-entry FIFO. It produces an even count of 512 results and is long enough to hold full-scale positive and negative runs over whole windows, which tests the exact 22-bit range. The second uses a 9-sample block with a two-entry FIFO. Its five results make the lone final firing occur, and the small FIFO makes backpressure reach the window after only a few results. Both copies run blocks with a free-flowing output, with random gaps on both sides plus a restart pulse mid-block, and with a long output stall followed by sparse draining.

// File: rtl/fir_win_pkg.sv
`timescale 1ns / 1ps
package fir_win_pkg;

   // Two neighbouring output positions are evaluated per window firing.
   localparam int LANES = 2;

   // Tap weight for position idx: odd values rising from 3.
   function automatic int tap_coef(input int idx);
      return 2 * idx + 3;
   endfunction

   // Sum of all weights, sets the exact accumulator width.
   function automatic int coef_sum(input int taps);
      int acc;
      acc = 0;
      for (int i = 0; i < taps; i++) acc += tap_coef(i);
      return acc;
   endfunction

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } run_state_e;

endpackage

// File: rtl/fir_win_buffer.sv
`timescale 1ns / 1ps
module fir_win_buffer #(
   parameter  int DATA_W    = 16,
   parameter  int TAPS      = 5,
   parameter  int BLOCK_LEN = 516,
   localparam int WIN       = TAPS + 1,
   localparam int CNT_W     = $clog2(WIN + 1),
   localparam int RX_W      = $clog2(BLOCK_LEN + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         run_i,
   input  logic                         clear_i,
   input  logic                         in_valid_i,
   input  logic [DATA_W-1:0]            in_data_i,
   output logic                         in_ready_o,
   input  logic                         adv_i,
   output logic                         fire_o,
   output logic                         pair_o,
   output logic [WIN-1:0][DATA_W-1:0]   win_o
);

   logic [WIN-1:0][DATA_W-1:0] win_q;
   logic [CNT_W-1:0]           cnt_q;
   logic [RX_W-1:0]            rx_q;
   logic                       take;
   logic                       full_win;
   logic                       tail_win;

   assign in_ready_o = run_i && (rx_q != RX_W'(BLOCK_LEN)) && (cnt_q != CNT_W'(WIN));
   assign take       = in_valid_i && in_ready_o;
   assign full_win   = (cnt_q == CNT_W'(WIN));
   // odd result count: last window holds exactly TAPS samples once the block is in
   assign tail_win   = (cnt_q == CNT_W'(TAPS)) && (rx_q == RX_W'(BLOCK_LEN));
   assign fire_o     = run_i && (full_win || tail_win) && adv_i;
   assign pair_o     = full_win;
   assign win_o      = win_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rx_q  <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
         rx_q  <= '0;
      end else if (take) begin
         cnt_q <= cnt_q + 1'b1;
         rx_q  <= rx_q + 1'b1;
      end else if (fire_o) begin
         cnt_q <= cnt_q - CNT_W'(2);
      end
   end

   // Slot i takes the next sample when it is the fill point; a firing drops the two oldest.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
      end else begin
         for (int i = 0; i < WIN; i++) begin
            if (fire_o && (i + 2 < WIN)) win_q[i] <= win_q[(i + 2) % WIN];
            else if (take && cnt_q == CNT_W'(i)) win_q[i] <= in_data_i;
         end
      end
   end

   // R9
   fire_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |-> (rx_q >= RX_W'(WIN) || rx_q == RX_W'(BLOCK_LEN)));

   // R4
   rx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !clear_i) |=> (rx_q == $past(rx_q) + 1'b1 && rx_q <= RX_W'(BLOCK_LEN)));

endmodule

// File: rtl/fir_pair_datapath.sv
`timescale 1ns / 1ps
module fir_pair_datapath #(
   parameter  int DATA_W = 16,
   parameter  int TAPS   = 5,
   parameter  int ACC_W  = 22,
   localparam int WIN    = TAPS + 1,
   localparam int LANES  = fir_win_pkg::LANES
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          fire_i,
   input  logic                          pair_i,
   input  logic [WIN-1:0][DATA_W-1:0]    win_i,
   input  logic                          push_ok_i,
   output logic                          adv_o,
   output logic                          res_v_o,
   output logic                          res_pair_o,
   output logic [LANES-1:0][ACC_W-1:0]   res_o
);

   logic s1_v_q, s1_pair_q, s2_v_q, s2_pair_q;
   logic adv2;

   // the whole pipe moves only where the stage ahead frees up
   assign adv2       = !s2_v_q || push_ok_i;
   assign adv_o      = !s1_v_q || adv2;
   assign res_v_o    = s2_v_q;
   assign res_pair_o = s2_pair_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v_q    <= 1'b0;
         s1_pair_q <= 1'b0;
         s2_v_q    <= 1'b0;
         s2_pair_q <= 1'b0;
      end else begin
         if (adv_o) begin
            s1_v_q    <= fire_i;
            s1_pair_q <= pair_i;
         end
         if (adv2) begin
            s2_v_q    <= s1_v_q;
            s2_pair_q <= s1_pair_q;
         end
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [TAPS-1:0][ACC_W-1:0] part;
      logic [ACC_W-1:0]           sum_q;

      for (genvar t = 0; t < TAPS; t++) begin : g_tap
         localparam logic signed [ACC_W-1:0] COEF = ACC_W'(fir_win_pkg::tap_coef(t));
         logic signed [ACC_W-1:0] prod_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prod_q <= '0;
            else if (adv_o) prod_q <= ACC_W'($signed(win_i[l + t])) * COEF;
         end

         if (t == 0) begin : g_head
            assign part[t] = prod_q;
         end else begin : g_link
            assign part[t] = part[t - 1] + prod_q;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sum_q <= '0;
         else if (adv2) sum_q <= part[TAPS - 1];
      end

      assign res_o[l] = sum_q;
   end

   // R6
   stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_v_o && !push_ok_i) |=> (res_v_o && $stable(res_o) && $stable(res_pair_o)));

endmodule

// File: rtl/fir_out_fifo.sv
`timescale 1ns / 1ps
module fir_out_fifo #(
   parameter  int W     = 22,
   parameter  int DEPTH = 4,
   parameter  int LANES = 2,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      push_v_i,
   input  logic                      push_two_i,
   input  logic [LANES-1:0][W-1:0]   push_data_i,
   output logic                      push_ok_o,
   output logic                      out_valid_o,
   input  logic                      out_ready_i,
   output logic [W-1:0]              out_data_o,
   output logic                      pop_o
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("fir_out_fifo: DEPTH must be a power of two, at least 2");
   end
   if (LANES != 2) begin : g_bad_lanes
      $error("fir_out_fifo: built for a two-wide write");
   end

   logic [W-1:0]     mem_q [DEPTH];
   logic [PTR_W-1:0] wptr_q, rptr_q;
   logic [CNT_W-1:0] count_q, free, need;
   logic             push;

   assign free        = CNT_W'(DEPTH) - count_q;
   assign need        = push_two_i ? CNT_W'(2) : CNT_W'(1);
   assign push_ok_o   = (free >= need);
   assign push        = push_v_i && push_ok_o;
   assign out_valid_o = (count_q != '0);
   assign out_data_o  = mem_q[rptr_q];
   assign pop_o       = out_valid_o && out_ready_i;

   always_ff @(posedge clk) begin
      if (push) begin
         mem_q[wptr_q] <= push_data_i[0];
         if (push_two_i) mem_q[wptr_q + 1'b1] <= push_data_i[1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         count_q <= '0;
      end else begin
         if (push) wptr_q <= wptr_q + PTR_W'(need);
         if (pop_o) rptr_q <= rptr_q + 1'b1;
         count_q <= count_q + (push ? need : CNT_W'(0)) - (pop_o ? CNT_W'(1) : CNT_W'(0));
      end
   end

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(DEPTH));

   // R6
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

endmodule

// File: rtl/fir_win_stream.sv
`timescale 1ns / 1ps
module fir_win_stream #(
   parameter  int DATA_W     = 16,
   parameter  int TAPS       = 5,
   parameter  int BLOCK_LEN  = 516,
   parameter  int FIFO_DEPTH = 4,
   localparam int ACC_W      = DATA_W + $clog2(fir_win_pkg::coef_sum(TAPS) + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              done_o,
   input  logic              in_valid_i,
   input  logic [DATA_W-1:0] in_data_i,
   output logic              in_ready_o,
   output logic              out_valid_o,
   output logic [ACC_W-1:0]  out_data_o,
   input  logic              out_ready_i
);
   import fir_win_pkg::*;

   localparam int WIN   = TAPS + 1;
   localparam int NOUT  = BLOCK_LEN - TAPS + 1;
   localparam int OC_W  = $clog2(NOUT + 1);

   if (TAPS < 2 || DATA_W < 2) begin : g_bad_shape
      $error("fir_win_stream: TAPS and DATA_W must be at least 2");
   end
   if (BLOCK_LEN < TAPS) begin : g_bad_len
      $error("fir_win_stream: BLOCK_LEN must cover at least one window");
   end

   run_state_e                  state_q;
   logic [OC_W-1:0]             oc_q;
   logic                        done_q;
   logic                        busy, launch, pop, last_pop;
   logic                        fire, pair, adv, res_v, res_pair, push_ok;
   logic [WIN-1:0][DATA_W-1:0]  win;
   logic [LANES-1:0][ACC_W-1:0] res;

   assign busy     = (state_q == ST_RUN);
   assign launch   = start_i && !busy;
   assign last_pop = pop && (oc_q == OC_W'(NOUT - 1));
   assign done_o   = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         oc_q    <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= last_pop;
         if (launch) begin
            state_q <= ST_RUN;
            oc_q    <= '0;
         end else if (pop) begin
            oc_q <= oc_q + 1'b1;
            if (last_pop) state_q <= ST_IDLE;
         end
      end
   end

   fir_win_buffer #(
      .DATA_W   (DATA_W),
      .TAPS     (TAPS),
      .BLOCK_LEN(BLOCK_LEN)
   ) u_buffer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (busy),
      .clear_i   (launch),
      .in_valid_i(in_valid_i),
      .in_data_i (in_data_i),
      .in_ready_o(in_ready_o),
      .adv_i     (adv),
      .fire_o    (fire),
      .pair_o    (pair),
      .win_o     (win)
   );

   fir_pair_datapath #(
      .DATA_W(DATA_W),
      .TAPS  (TAPS),
      .ACC_W (ACC_W)
   ) u_datapath (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire_i    (fire),
      .pair_i    (pair),
      .win_i     (win),
      .push_ok_i (push_ok),
      .adv_o     (adv),
      .res_v_o   (res_v),
      .res_pair_o(res_pair),
      .res_o     (res)
   );

   fir_out_fifo #(
      .W    (ACC_W),
      .DEPTH(FIFO_DEPTH),
      .LANES(LANES)
   ) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_v_i   (res_v),
      .push_two_i (res_pair),
      .push_data_i(res),
      .push_ok_o  (push_ok),
      .out_valid_o(out_valid_o),
      .out_ready_i(out_ready_i),
      .out_data_o (out_data_o),
      .pop_o      (pop)
   );

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7
   done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(out_valid_o && out_ready_i));

   // R8
   restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy && !last_pop) |=> (busy && in_ready_o == $past(in_ready_o) || !$past(in_ready_o) || $past(in_valid_i)));

endmodule

// File: tb/fir_win_stream_bench.sv
`timescale 1ns / 1ps
module fir_win_stream_harness #(
   parameter int BLOCK_LEN  = 516,
   parameter int FIFO_DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   output int   checks,
   output int   fails,
   output logic finished
);
   localparam int NOUT  = BLOCK_LEN - 4;
   localparam int FIRST = (BLOCK_LEN < 6) ? BLOCK_LEN : 6;

   logic        start, done, in_valid, in_ready, out_valid, out_ready;
   logic [15:0] in_data;
   logic [21:0] out_data;

   fir_win_stream #(
      .DATA_W    (16),
      .TAPS      (5),
      .BLOCK_LEN (BLOCK_LEN),
      .FIFO_DEPTH(FIFO_DEPTH)
   ) u_fir_win_stream (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .done_o     (done),
      .in_valid_i (in_valid),
      .in_data_i  (in_data),
      .in_ready_o (in_ready),
      .out_valid_o(out_valid),
      .out_data_o (out_data),
      .out_ready_i(out_ready)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s (N=%0d) actual=%0d expected=%0d", req, what, BLOCK_LEN, act, exp);
      end
   endtask

   task automatic idle_check(input string req);
      repeat (3) begin
         @(negedge clk);
         check(!in_ready && !out_valid && !done, req, "idle outputs low",
               {in_ready, out_valid, done}, 0);
      end
   endtask

   // pattern: 0 full-scale runs, 1 random, 2 ramp; mode: 0 free flow, 1 random gaps, 2 long stall
   task automatic run_block(input int pattern, input int mode);
      int          xs[$];
      int          exp_q[$];
      int          sent, got, cyc;
      bit          pend_done, hold, glitched;
      logic [21:0] held;
      for (int i = 0; i < BLOCK_LEN; i++) begin
         int v;
         case (pattern)
            0:       v = (i < BLOCK_LEN / 2) ? 32767 : -32768;
            1:       v = $signed(16'($urandom));
            default: v = ((i * 37) % 2000) - 1000;
         endcase
         xs.push_back(v);
      end
      for (int k = 0; k < NOUT; k++) begin
         int e;
         e = 0;
         for (int j = 0; j < 5; j++) e += (2 * j + 3) * xs[k + j];
         exp_q.push_back(e);
      end
      sent = 0; got = 0; cyc = 0; pend_done = 0; hold = 0; glitched = 0; held = '0;
      start = 1'b1;
      while (!(got == NOUT && !pend_done)) begin
         @(negedge clk);
         cyc++;
         // R7
         if (pend_done || done) check(done == pend_done, "R7", "done level", done, pend_done);
         pend_done = 0;
         // R6
         if (hold) check(out_valid && out_data == held, "R6", "stalled output held", out_data, held);
         if (out_valid && got >= NOUT) check(0, "R3", "extra result", got + 1, NOUT);
         // R9
         if (out_valid && sent < FIRST) check(0, "R9", "result before window filled", sent, FIRST);
         if (in_ready && sent >= BLOCK_LEN) check(0, "R4", "ready after last sample", sent + 1, BLOCK_LEN);
         start = 1'b0;
         if (mode == 1 && sent == 3 && !glitched) begin
            start    = 1'b1; // R8 restart pulse mid-block
            glitched = 1;
         end
         in_valid = (sent < BLOCK_LEN) && (mode == 0 || ($urandom % 4 != 0));
         in_data  = (sent < BLOCK_LEN) ? 16'(xs[sent]) : 16'h0;
         case (mode)
            0:       out_ready = 1'b1;
            1:       out_ready = 1'($urandom % 2);
            default: out_ready = (cyc > 80) && (cyc % 4 == 0);
         endcase
         hold = out_valid && !out_ready;
         held = out_data;
         if (in_valid && in_ready) sent++;
         if (out_valid && out_ready) begin
            if (got < NOUT)
               check($signed(out_data) == exp_q[got],
                     ((NOUT % 2 == 1) && (got == NOUT - 1)) ? "R5" : "R2",
                     $sformatf("result[%0d]", got), $signed(out_data), exp_q[got]);
            got++;
            if (got == NOUT) pend_done = 1;
         end
         if (cyc > 20000) break;
      end
      in_valid  = 1'b0;
      out_ready = 1'b0;
      start     = 1'b0;
      check(sent == BLOCK_LEN, "R4", "samples taken", sent, BLOCK_LEN);
      check(got == NOUT, "R3", "results delivered", got, NOUT);
      if (glitched) check(sent == BLOCK_LEN && got == NOUT, "R8", "block intact after restart pulse", got, NOUT);
      idle_check("R4");
   endtask

   initial begin
      checks = 0; fails = 0; finished = 1'b0;
      start = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
      wait (rst_n == 1'b1);
      @(negedge clk);
      // R1 reset state
      check(!in_ready && !out_valid && !done, "R1", "reset outputs", {in_ready, out_valid, done}, 0);
      idle_check("R1");
      run_block(0, 0);
      run_block(1, 1);
      run_block(2, 2);
      run_block(1, 0);
      finished = 1'b1;
   end
endmodule

module fir_win_stream_bench;
   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   int   ca, fa, cb, fb;
   logic fin_a, fin_b;

   always #2 clk = ~clk;

   fir_win_stream_harness #(.BLOCK_LEN(516), .FIFO_DEPTH(4)) u_fir_win_stream (
      .clk(clk), .rst_n(rst_n), .checks(ca), .fails(fa), .finished(fin_a));

   fir_win_stream_harness #(.BLOCK_LEN(9), .FIFO_DEPTH(2)) u_fir_win_stream_short (
      .clk(clk), .rst_n(rst_n), .checks(cb), .fails(fb), .finished(fin_b));

   initial begin
      int wd_fail;
      int cyc;
      wd_fail = 0;
      cyc     = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      while (!(fin_a === 1'b1 && fin_b === 1'b1) && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!(fin_a === 1'b1 && fin_b === 1'b1)) begin
         wd_fail = 1;
         $display("FAIL watchdog R3 run incomplete actual=%0d expected=%0d", cyc, 100000);
      end
      $display("TB_RESULT checks=%0d failures=%0d", ca + cb + wd_fail, fa + fb + wd_fail);
      $finish;
   end
endmodule